// File: doc/BRIEF.md
# Asymmetric PWM Timer with Buffered Reload

This block generates one pulse-width-modulated output from an up-counter. The counter runs from zero to one less than the active period value and then starts again at zero. A compare value sets how many cycles of each period sit at the asserted level. A control word chooses whether the PWM output is driven, whether the counter runs, and which output level the compare interval stands for.

Software reaches the block through a small word-addressed write/read port. Each timing value has two copies: an active pair and a buffered pair. While the timer is stopped, software writes the active pair and the change applies at once. While it runs, software writes the buffered pair. The block copies the buffered pair into the active pair on the cycle the counter wraps, and only when a buffered write is waiting. The period already under way therefore ends with its original timing.

Top module: `apwm_timer`

## Requirements
- R1: After reset the output is low, the counter is stopped at zero, and every register reads as zero.
- R2: Registers sit at byte offsets 0x08 (active period), 0x0C (active compare), 0x10 (buffered period) and 0x14 (buffered compare). The 16-bit control word occupies bits 31:16 of the word at 0x28, which is halfword offset 0x2A. Writes honour the byte enables (bit i covers data bits 8i+7:8i), and reads return the stored values. Unmapped addresses read as zero and ignore writes.
- R3: While control bit 4 (run) is set, the counter steps by one each cycle from 0 to period−1 and then wraps to 0. The first counted cycle follows the edge that sets the bit.
- R4: With control bit 9 (output mode) set and bit 10 clear, the output is high while the counter is below the compare value and low otherwise.
- R5: A compare value of 0 gives a constant low output. A compare value at or above the period gives a constant high output.
- R6: With control bit 10 set, the output is inverted, so the compare value sets the low time of each period.
- R7: While control bit 9 is clear, the output is low whatever the counter and run bit do.
- R8: A buffered write made while the timer runs leaves the current period unchanged, and the active registers keep their old values until the wrap.
- R9: On the wrap cycle, a pending buffered pair is copied into the active pair and the pending state clears. With nothing pending, no copy takes place.
- R10: Control bits 7 and 6 are stored and read back. No sync path exists, so they never change the counter or the output.
- R11: Clearing the run bit freezes the counter at its value, and the output holds its level. Setting the bit again resumes counting from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address; bits 7:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 1 | PWM output |

## Verification
The waveform is compared cycle by cycle against a counter model in the bench. It is driven with two unrelated period/compare pairs and with the compare value at zero, equal to the period and above it. These show whether the wrap point is off by one, and whether the compare uses a strict or an inclusive bound. The same pair is then run with the polarity bit set, with the mode bit clear and with the sync bits set, to separate inversion from gating from bits that must have no effect. A stop-and-resume pattern shows that the counter freezes rather than resets. A buffered write made mid-period shows that the new values hold back until the wrap, and a run with no buffered write shows that no copy happens when nothing is pending.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
   // word indices (byte offset / 4) of the mapped registers
   localparam int unsigned IDX_ACT_PER = 2;
   localparam int unsigned IDX_ACT_CMP = 3;
   localparam int unsigned IDX_BUF_PER = 4;
   localparam int unsigned IDX_BUF_CMP = 5;
   localparam int unsigned IDX_CTRL    = 10;
   // control word sits in the upper half of its bus word
   localparam int unsigned CTRL_LSB    = 16;
   localparam int unsigned CTRL_W      = 16;
   // control bit positions
   localparam int unsigned CB_RUN      = 4;
   localparam int unsigned CB_SYNC_A   = 6;
   localparam int unsigned CB_SYNC_B   = 7;
   localparam int unsigned CB_MODE     = 9;
   localparam int unsigned CB_POL_LOW  = 10;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
   import apwm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic              period_end,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CNT_W-1:0]  act_per,
   output logic [CNT_W-1:0]  act_cmp,
   output logic [CNT_W-1:0]  buf_per,
   output logic [CNT_W-1:0]  buf_cmp,
   output logic [CTRL_W-1:0] ctrl,
   output logic              pending
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0]  word_idx;
   logic [DATA_W-1:0] cur_word;
   logic [DATA_W-1:0] merged;
   logic              hit_aper, hit_acmp, hit_bper, hit_bcmp, hit_ctrl;
   logic              transfer;

   assign word_idx = bus_addr[ADDR_W-1:2];
   assign hit_aper = (word_idx == IDX_W'(IDX_ACT_PER));
   assign hit_acmp = (word_idx == IDX_W'(IDX_ACT_CMP));
   assign hit_bper = (word_idx == IDX_W'(IDX_BUF_PER));
   assign hit_bcmp = (word_idx == IDX_W'(IDX_BUF_CMP));
   assign hit_ctrl = (word_idx == IDX_W'(IDX_CTRL));

   always_comb begin
      cur_word = '0;
      if (hit_aper)      cur_word = DATA_W'(act_per);
      else if (hit_acmp) cur_word = DATA_W'(act_cmp);
      else if (hit_bper) cur_word = DATA_W'(buf_per);
      else if (hit_bcmp) cur_word = DATA_W'(buf_cmp);
      else if (hit_ctrl) cur_word = DATA_W'(ctrl) << CTRL_LSB;
   end

   assign bus_rdata = cur_word;

   // byte-lane merge of write data over the addressed register
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[8*g +: 8] = bus_be[g] ? bus_wdata[8*g +: 8] : cur_word[8*g +: 8];
   end

   assign transfer = period_end && pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_per <= '0;
         act_cmp <= '0;
         buf_per <= '0;
         buf_cmp <= '0;
         ctrl    <= '0;
         pending <= 1'b0;
      end else begin
         if (bus_we && hit_aper)      act_per <= merged[CNT_W-1:0];
         else if (transfer)           act_per <= buf_per;

         if (bus_we && hit_acmp)      act_cmp <= merged[CNT_W-1:0];
         else if (transfer)           act_cmp <= buf_cmp;

         if (bus_we && hit_bper)      buf_per <= merged[CNT_W-1:0];
         if (bus_we && hit_bcmp)      buf_cmp <= merged[CNT_W-1:0];
         if (bus_we && hit_ctrl)      ctrl    <= merged[CTRL_LSB +: CTRL_W];

         if (bus_we && (hit_bper || hit_bcmp)) pending <= 1'b1;
         else if (transfer)                    pending <= 1'b0;
      end
   end
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             period_end
);
   logic at_top;

   // a period of 0 or 1 keeps the counter parked at zero
   assign at_top     = (period <= CNT_W'(1)) || (count >= period - CNT_W'(1));
   assign period_end = run && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (run) count <= at_top ? '0 : count + CNT_W'(1);
   end
endmodule

// File: rtl/apwm_compare.sv
module apwm_compare #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             mode_on,
   input  logic             pol_low,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp,
   output logic             pwm
);
   logic in_window;

   assign in_window = (count < cmp);
   assign pwm       = mode_on & (in_window ^ pol_low);
endmodule

// File: rtl/apwm_timer.sv
module apwm_timer
   import apwm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_we,
   input  logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                pwm_out
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("apwm_timer: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < CTRL_LSB + CTRL_W || (DATA_W % 8) != 0) begin : g_bad_data
      $error("apwm_timer: DATA_W must be a multiple of 8 and at least 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("apwm_timer: ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0]  act_per, act_cmp, buf_per, buf_cmp, count;
   logic [CTRL_W-1:0] ctrl;
   logic              pending, period_end;

   apwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_we     (bus_we),
      .bus_be     (bus_be),
      .period_end (period_end),
      .bus_rdata  (bus_rdata),
      .act_per    (act_per),
      .act_cmp    (act_cmp),
      .buf_per    (buf_per),
      .buf_cmp    (buf_cmp),
      .ctrl       (ctrl),
      .pending    (pending)
   );

   apwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl[CB_RUN]),
      .period     (act_per),
      .count      (count),
      .period_end (period_end)
   );

   apwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .mode_on (ctrl[CB_MODE]),
      .pol_low (ctrl[CB_POL_LOW]),
      .count   (count),
      .cmp     (act_cmp),
      .pwm     (pwm_out)
   );
endmodule

// File: rtl/apwm_timer_chk.sv
module apwm_timer_chk
   import apwm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              pwm_out,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  act_per,
   input logic [CNT_W-1:0]  act_cmp,
   input logic [CTRL_W-1:0] ctrl
);
   logic act_wr;
   assign act_wr = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_ACT_PER) ||
                              bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_ACT_CMP));

   // R3: running counter either steps by one or restarts at zero
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_RUN] |=> (count == '0 || count == $past(count) + CNT_W'(1)));

   // R11: stopped counter holds
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CB_RUN] |=> $stable(count));

   // R7: output gated low when mode is off
   a_r7_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CB_MODE] |-> !pwm_out);

   // R5: zero compare with normal polarity is constant low
   a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_MODE] && !ctrl[CB_POL_LOW] && act_cmp == '0) |-> !pwm_out);

   // R5: compare at/above a nonzero period is constant high
   a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_MODE] && !ctrl[CB_POL_LOW] && act_per != '0 && act_cmp >= act_per) |-> pwm_out);

   // R6: inverted polarity with zero compare is constant high
   a_r6_inv_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_MODE] && ctrl[CB_POL_LOW] && act_cmp == '0) |-> pwm_out);

   // R8: active pair only changes on a bus write or at a wrap
   a_r8_mid_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(act_wr) && count != '0) |-> ($stable(act_per) && $stable(act_cmp)));
endmodule

bind apwm_timer apwm_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .pwm_out  (pwm_out),
   .count    (count),
   .act_per  (act_per),
   .act_cmp  (act_cmp),
   .ctrl     (ctrl)
);

// File: tb/apwm_timer_bench.sv
module apwm_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   apwm_timer u_apwm_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic do_reset();
      rst_n = 1'b0;
      bus_we = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wctl(input logic [15:0] v);
      wr(8'h28, {v, 16'h0}, 4'b1100);
   endtask

   task automatic setup_start(input int per, input int cmp, input logic [15:0] c);
      do_reset();
      wr(8'h08, per, 4'hF);
      wr(8'h0C, cmp, 4'hF);
      wctl(c);
   endtask

   // k0 = counter value at the current falling edge
   task automatic expect_wave(input string req, input int n, input int per, input int cmp,
                              input bit pol, input bit mode, input int k0);
      for (int i = 0; i < n; i++) begin
         int c;
         c = (k0 + i) % per;
         check(req, {31'h0, pwm_out}, {31'h0, mode & ((c < cmp) ^ pol)});
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      check("R1 out", {31'h0, pwm_out}, 32'h0);
      rd(8'h08, d); check("R1 aper", d, 0);
      rd(8'h0C, d); check("R1 acmp", d, 0);
      rd(8'h10, d); check("R1 bper", d, 0);
      rd(8'h14, d); check("R1 bcmp", d, 0);
      rd(8'h28, d); check("R1 ctrl", d, 0);
      repeat (3) @(negedge clk);
      check("R1 out idle", {31'h0, pwm_out}, 32'h0);
   endtask

   task automatic t_bus();
      logic [31:0] d;
      do_reset();
      wr(8'h08, 32'h12345678, 4'hF);
      rd(8'h08, d); check("R2 R9 aper readback", d, 32'h12345678);
      wr(8'h0C, 32'hAABBCCDD, 4'b0001);
      rd(8'h0C, d); check("R2 be lane0", d, 32'h000000DD);
      wr(8'h0C, 32'hAABBCCDD, 4'b1010);
      rd(8'h0C, d); check("R2 be lanes1,3", d, 32'hAA00CCDD);
      wr(8'h14, 32'h00000777, 4'hF);
      rd(8'h14, d); check("R2 bcmp", d, 32'h777);
      wr(8'h00, 32'hFFFFFFFF, 4'hF);
      rd(8'h00, d); check("R2 unmapped 0x00", d, 0);
      wr(8'h30, 32'hFFFFFFFF, 4'hF);
      rd(8'h30, d); check("R2 unmapped 0x30", d, 0);
      wctl(16'h06D0);
      rd(8'h28, d); check("R2 R10 ctrl readback", d, 32'h06D00000);
   endtask

   task automatic t_normal();
      logic [31:0] d;
      setup_start(10, 3, 16'h0210);
      expect_wave("R3 R4 per10 cmp3", 25, 10, 3, 0, 1, 0);
      setup_start(7, 5, 16'h0210);
      expect_wave("R3 R4 R9 per7 cmp5 no pending", 30, 7, 5, 0, 1, 0);
      rd(8'h08, d); check("R9 no copy without pending", d, 7);
   endtask

   task automatic t_edges();
      setup_start(6, 0, 16'h0210);
      expect_wave("R5 cmp zero low", 14, 6, 0, 0, 1, 0);
      setup_start(6, 6, 16'h0210);
      expect_wave("R5 cmp equal high", 14, 6, 6, 0, 1, 0);
      setup_start(6, 9, 16'h0210);
      expect_wave("R5 cmp above high", 14, 6, 9, 0, 1, 0);
   endtask

   task automatic t_pol();
      setup_start(8, 3, 16'h0610);
      expect_wave("R6 inverted", 20, 8, 3, 1, 1, 0);
   endtask

   task automatic t_mode_off();
      setup_start(8, 3, 16'h0010);
      expect_wave("R7 mode off running", 12, 8, 3, 0, 0, 0);
      wctl(16'h0000);
      expect_wave("R7 mode and run off", 6, 8, 3, 0, 0, 0);
   endtask

   task automatic t_sync();
      setup_start(10, 3, 16'h02D0);
      expect_wave("R10 sync bits no effect", 25, 10, 3, 0, 1, 0);
   endtask

   task automatic t_hold();
      setup_start(10, 5, 16'h0210);
      expect_wave("R11 pre-stop", 3, 10, 5, 0, 1, 0);
      wctl(16'h0200);  // edge still counts: frozen at 4
      for (int i = 0; i < 6; i++) begin
         check("R11 frozen high", {31'h0, pwm_out}, 32'h1);
         @(negedge clk);
      end
      wctl(16'h0210);  // run off at this edge: still 4
      expect_wave("R11 resume", 12, 10, 5, 0, 1, 4);
   endtask

   task automatic t_shadow();
      logic [31:0] d;
      setup_start(8, 2, 16'h0210);
      expect_wave("R8 before", 3, 8, 2, 0, 1, 0);
      wr(8'h10, 32'd12, 4'hF);
      wr(8'h14, 32'd6, 4'hF);
      rd(8'h08, d); check("R8 active per kept", d, 8);
      rd(8'h0C, d); check("R8 active cmp kept", d, 2);
      expect_wave("R8 period finishes", 3, 8, 2, 0, 1, 5);
      expect_wave("R9 new timing", 26, 12, 6, 0, 1, 0);
      rd(8'h08, d); check("R9 per copied", d, 12);
      rd(8'h0C, d); check("R9 cmp copied", d, 6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_bus();
      t_normal();
      t_edges();
      t_pol();
      t_mode_off();
      t_sync();
      t_hold();
      t_shadow();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule